// File: doc/BRIEF.md
# Branch Decision and Count/Link Register Unit

This block resolves conditional branches for a 32-bit processor pipeline. Each branch request arrives in a single cycle and carries:

- a condition word and a condition-bit mask;
- a three-bit test code;
- a target-source select and an external target address;
- the sequential (fall-through) address;
- two flags: one asks for a count decrement, the other for a link write.

The unit holds the count register and the link register. It may decrement the count register and test the result for zero or nonzero. It can also combine that count test with a masked condition-bit test. From the outcome it produces a registered taken flag and the next instruction address one cycle later.

A separate move port reads and writes either register, so surrounding logic can load a loop count or save and restore a return address. Taken targets are always word aligned: the two low address bits are cleared. A branch that wants to update a register takes priority over a move write to that same register in the same cycle.

The unit has no multi-state sequencing. The only state is:

- the two registers;
- the one-deep result register.

The result register has two conditions, named IDLE and RESOLVED. It is RESOLVED for exactly one cycle after each request cycle and IDLE otherwise.

Top module: `branch_unit`

## Requirements
- R1: Test codes 0 (count nonzero) and 3 (count zero) decide on the count value alone. The count value is the effective value described in R3.
- R2: Codes 1, 4 and 6 additionally require the masked bit to be set. Codes 2, 5 and 7 require it to be clear. Codes 1 and 2 pair with count nonzero, codes 4 and 5 with count zero, and codes 6 and 7 ignore the count. The masked bit counts as set when the bitwise AND of the condition word and the mask is nonzero.
- R3: When the decrement flag is set on a request, the count register becomes its value minus one (wrapping from 0 to all ones) at the clock edge. The zero test of that same request uses the decremented value.
- R4: A taken branch produces its target with bits [1:0] cleared. The target source is selected as follows: select 1 uses the count register, select 2 uses the link register, and selects 0 and 3 use the external target. A register source uses the value held before this request's own update.
- R5: A request that is not taken produces the sequential address unchanged.
- R6: When the link flag is set on a request, the link register is loaded with the sequential address at the clock edge, whether or not the branch is taken.
- R7: On the move port, select 0 addresses the count register and select 1 addresses the link register. A write takes effect at the clock edge. The read data shows the currently held value of the selected register.
- R8: When a request decrements the count register or loads the link register, a move write to that same register in that cycle is discarded. A move write to the other register still takes effect.
- R9: The result valid output is high exactly one cycle after a request cycle. While it is low, the taken flag and the next address are zero.
- R10: After reset, both registers and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | Branch request present this cycle |
| br_test | input | 3 | Test code (R1, R2) |
| br_dec | input | 1 | Decrement the count register before testing |
| br_link | input | 1 | Load the link register with the sequential address |
| br_tgt_sel | input | 2 | Target source: 1 count, 2 link, 0/3 external |
| br_cond | input | 32 | Condition word |
| br_mask | input | 32 | Condition-bit mask |
| br_target | input | 32 | External indirect target |
| br_seq_addr | input | 32 | Sequential next address |
| mv_wr | input | 1 | Move-port write strobe |
| mv_sel | input | 1 | Move-port register select: 0 count, 1 link |
| mv_wdata | input | 32 | Move-port write data |
| mv_rdata | output | 32 | Move-port read data |
| res_valid | output | 1 | Result present (RESOLVED) |
| res_taken | output | 1 | Branch taken |
| res_next_addr | output | 32 | Next instruction address |

## Verification
The embedded assertions check the following on every cycle:

- each register's update rules: decrement by one, link load, move write and hold;
- word alignment of taken addresses;
- the sequential address on a not-taken result;
- the IDLE/RESOLVED timing of the result outputs.

Other behaviours are shown only by the bench's scenarios, compared cycle by cycle against a behavioural model:

- the full truth table of the eight test codes;
- decrementing through one to zero and wrapping below zero;
- choosing a register target from its value before the update;
- the priority between a branch and a move on the same register.

// File: rtl/branch_pkg.sv
package branch_pkg;

    typedef enum logic [2:0] {
        TST_CNZ   = 3'd0,
        TST_CNZ_T = 3'd1,
        TST_CNZ_F = 3'd2,
        TST_CZ    = 3'd3,
        TST_CZ_T  = 3'd4,
        TST_CZ_F  = 3'd5,
        TST_BT    = 3'd6,
        TST_BF    = 3'd7
    } br_test_e;

    typedef enum logic [1:0] {
        TGT_EXT   = 2'd0,
        TGT_CTR   = 2'd1,
        TGT_LR    = 2'd2,
        TGT_EXT_B = 2'd3
    } br_tgt_e;

    typedef enum logic {
        RES_IDLE     = 1'b0,
        RES_RESOLVED = 1'b1
    } res_state_e;

endpackage

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
    import branch_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2:0]   test_code,
    input  logic [W-1:0] ctr_eff,
    input  logic [W-1:0] cond_word,
    input  logic [W-1:0] cond_mask,
    output logic         taken
);
    logic ctr_zero;
    logic bit_set;
    br_test_e code;

    assign code     = br_test_e'(test_code);
    assign ctr_zero = (ctr_eff == '0);
    assign bit_set  = |(cond_word & cond_mask);

    always_comb begin
        taken = 1'b0;
        unique case (code)
            TST_CNZ:   taken = !ctr_zero;
            TST_CNZ_T: taken = !ctr_zero &&  bit_set;
            TST_CNZ_F: taken = !ctr_zero && !bit_set;
            TST_CZ:    taken =  ctr_zero;
            TST_CZ_T:  taken =  ctr_zero &&  bit_set;
            TST_CZ_F:  taken =  ctr_zero && !bit_set;
            TST_BT:    taken =  bit_set;
            TST_BF:    taken = !bit_set;
            default:   taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/branch_spr_file.sv
module branch_spr_file #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dec_en,
    input  logic         link_en,
    input  logic [W-1:0] link_val,
    input  logic         mv_wr,
    input  logic         mv_sel,
    input  logic [W-1:0] mv_wdata,
    output logic [W-1:0] ctr_q,
    output logic [W-1:0] lr_q
);
    logic mv_ctr_wr;
    logic mv_lr_wr;

    assign mv_ctr_wr = mv_wr && !mv_sel;
    assign mv_lr_wr  = mv_wr &&  mv_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else if (dec_en) begin
            ctr_q <= ctr_q - W'(1);
        end else if (mv_ctr_wr) begin
            ctr_q <= mv_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lr_q <= '0;
        end else if (link_en) begin
            lr_q <= link_val;
        end else if (mv_lr_wr) begin
            lr_q <= mv_wdata;
        end
    end

    AST_CTR_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_en |=> (ctr_q == $past(ctr_q) - W'(1)));                      // R3
    AST_LR_LINK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        link_en |=> (lr_q == $past(link_val)));                           // R6
    AST_CTR_MOVE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_wr && !mv_sel && !dec_en) |=> (ctr_q == $past(mv_wdata)));    // R7
    AST_LR_MOVE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_wr && mv_sel && !link_en) |=> (lr_q == $past(mv_wdata)));     // R7
    AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_en && !(mv_wr && !mv_sel)) |=> $stable(ctr_q));             // R8
    AST_LR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_en && !(mv_wr && mv_sel)) |=> $stable(lr_q));              // R8
endmodule

// File: rtl/branch_unit.sv
module branch_unit
    import branch_pkg::*;
#(
    parameter int W          = 32,
    parameter int ALIGN_BITS = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         br_valid,
    input  logic [2:0]   br_test,
    input  logic         br_dec,
    input  logic         br_link,
    input  logic [1:0]   br_tgt_sel,
    input  logic [31:0]  br_cond,
    input  logic [31:0]  br_mask,
    input  logic [31:0]  br_target,
    input  logic [31:0]  br_seq_addr,
    input  logic         mv_wr,
    input  logic         mv_sel,
    input  logic [31:0]  mv_wdata,
    output logic [31:0]  mv_rdata,
    output logic         res_valid,
    output logic         res_taken,
    output logic [31:0]  res_next_addr
);
    localparam logic [W-1:0] ALIGN_MASK = {{(W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

    logic [W-1:0] ctr_q;
    logic [W-1:0] lr_q;
    logic [W-1:0] ctr_eff;
    logic [W-1:0] tgt_raw;
    logic [W-1:0] next_addr;
    logic         dec_en;
    logic         link_en;
    logic         cond_taken;
    res_state_e   state_q;
    res_state_e   state_d;
    logic         taken_q;
    logic [W-1:0] addr_q;

    assign dec_en  = br_valid && br_dec;
    assign link_en = br_valid && br_link;
    assign ctr_eff = br_dec ? (ctr_q - W'(1)) : ctr_q;

    branch_spr_file #(.W(W)) spr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .dec_en   (dec_en),
        .link_en  (link_en),
        .link_val (br_seq_addr),
        .mv_wr    (mv_wr),
        .mv_sel   (mv_sel),
        .mv_wdata (mv_wdata),
        .ctr_q    (ctr_q),
        .lr_q     (lr_q)
    );

    branch_cond_eval #(.W(W)) eval_i (
        .test_code (br_test),
        .ctr_eff   (ctr_eff),
        .cond_word (br_cond),
        .cond_mask (br_mask),
        .taken     (cond_taken)
    );

    always_comb begin
        unique case (br_tgt_e'(br_tgt_sel))
            TGT_CTR:   tgt_raw = ctr_q;
            TGT_LR:    tgt_raw = lr_q;
            TGT_EXT,
            TGT_EXT_B: tgt_raw = br_target;
            default:   tgt_raw = br_target;
        endcase
        next_addr = cond_taken ? (tgt_raw & ALIGN_MASK) : br_seq_addr;
        state_d   = br_valid ? RES_RESOLVED : RES_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RES_IDLE;
            taken_q <= 1'b0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_d)
                RES_RESOLVED: begin
                    taken_q <= cond_taken;
                    addr_q  <= next_addr;
                end
                RES_IDLE: begin
                    taken_q <= 1'b0;
                    addr_q  <= '0;
                end
                default: begin
                    taken_q <= 1'b0;
                    addr_q  <= '0;
                end
            endcase
        end
    end

    always_comb begin
        res_valid     = (state_q == RES_RESOLVED);
        res_taken     = taken_q;
        res_next_addr = addr_q;
        mv_rdata      = mv_sel ? lr_q : ctr_q;
    end

    AST_TAKEN_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        res_taken |-> (res_next_addr[ALIGN_BITS-1:0] == '0));                     // R4
    AST_NOT_TAKEN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !cond_taken) |=> (res_next_addr == $past(br_seq_addr)));     // R5
    AST_RESOLVED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> res_valid);                                                  // R9
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |=> !res_valid);                                                // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_taken && res_next_addr == '0));                      // R9
    AST_CZ_AFTER_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_dec && br_test == 3'd3 && ctr_q == W'(1)) |=> res_taken); // R3
endmodule

// File: tb/branch_unit_tb_top.sv
module branch_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid, br_dec, br_link, mv_wr, mv_sel;
    logic [2:0]  br_test;
    logic [1:0]  br_tgt_sel;
    logic [31:0] br_cond, br_mask, br_target, br_seq_addr, mv_wdata;
    logic [31:0] mv_rdata, res_next_addr;
    logic        res_valid, res_taken;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] m_ctr, m_lr, e_addr;
    logic        e_valid, e_taken;

    always #4 clk = ~clk;

    branch_unit dut_i (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_test(br_test),
        .br_dec(br_dec), .br_link(br_link), .br_tgt_sel(br_tgt_sel),
        .br_cond(br_cond), .br_mask(br_mask), .br_target(br_target),
        .br_seq_addr(br_seq_addr), .mv_wr(mv_wr), .mv_sel(mv_sel),
        .mv_wdata(mv_wdata), .mv_rdata(mv_rdata), .res_valid(res_valid),
        .res_taken(res_taken), .res_next_addr(res_next_addr)
    );

    // Behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        logic [31:0] c, t;
        logic        bs, cz, tk;
        if (!rst_n) begin
            m_ctr = 0; m_lr = 0; e_valid = 0; e_taken = 0; e_addr = 0;
        end else begin
            c  = br_dec ? m_ctr - 1 : m_ctr;
            cz = (c == 0);
            bs = ((br_cond & br_mask) != 0);
            case (br_test)
                3'd0: tk = !cz;
                3'd1: tk = !cz && bs;
                3'd2: tk = !cz && !bs;
                3'd3: tk = cz;
                3'd4: tk = cz && bs;
                3'd5: tk = cz && !bs;
                3'd6: tk = bs;
                default: tk = !bs;
            endcase
            t = (br_tgt_sel == 2'd1) ? m_ctr : (br_tgt_sel == 2'd2) ? m_lr : br_target;
            e_valid = br_valid;
            e_taken = br_valid && tk;
            e_addr  = !br_valid ? 32'h0 : tk ? {t[31:2], 2'b00} : br_seq_addr;
            if (br_valid && br_dec) m_ctr = c;
            else if (mv_wr && !mv_sel) m_ctr = mv_wdata;
            if (br_valid && br_link) m_lr = br_seq_addr;
            else if (mv_wr && mv_sel) m_lr = mv_wdata;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_in();
        br_valid = 0; br_test = 0; br_dec = 0; br_link = 0; br_tgt_sel = 0;
        br_cond = 0; br_mask = 0; br_target = 0; br_seq_addr = 0;
        mv_wr = 0; mv_sel = 0; mv_wdata = 0;
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        #2;
        check({tag, " valid"}, {31'b0, res_valid}, {31'b0, e_valid});
        check({tag, " taken"}, {31'b0, res_taken}, {31'b0, e_taken});
        check({tag, " addr"}, res_next_addr, e_addr);
        check({tag, " rdata"}, mv_rdata, mv_sel ? m_lr : m_ctr);
    endtask

    task automatic req(input logic [2:0] code, input logic dec, input logic [1:0] sel,
                       input logic [31:0] cond, input logic [31:0] mask,
                       input logic [31:0] tgt, input logic [31:0] seq);
        idle_in();
        br_valid = 1; br_test = code; br_dec = dec; br_tgt_sel = sel;
        br_cond = cond; br_mask = mask; br_target = tgt; br_seq_addr = seq;
    endtask

    task automatic mv(input logic sel, input logic [31:0] d);
        idle_in();
        mv_wr = 1; mv_sel = sel; mv_wdata = d;
    endtask

    initial begin
        idle_in();
        repeat (3) @(posedge clk);
        #2;
        check("R10 valid", {31'b0, res_valid}, 0);
        check("R10 addr", res_next_addr, 0);
        check("R10 ctr", mv_rdata, 0);
        rst_n = 1;

        mv(0, 32'd3); cyc("R7");
        check("R7 ctr write", mv_rdata, 32'd3);
        mv(1, 32'h1000); cyc("R7");
        check("R7 lr write", mv_rdata, 32'h1000);

        req(3'd0, 1, 2'd0, 0, 0, 32'h2003, 32'h104); cyc("R3");
        check("R1 taken", {31'b0, res_taken}, 1);
        check("R4 aligned", res_next_addr, 32'h2000);
        idle_in(); cyc("R9");
        check("R3 ctr after dec", mv_rdata, 32'd2);
        check("R9 idle valid", {31'b0, res_valid}, 0);

        req(3'd3, 1, 2'd0, 0, 0, 32'h3001, 32'h108); cyc("R5");
        check("R5 seq", res_next_addr, 32'h108);
        req(3'd3, 1, 2'd0, 0, 0, 32'h3001, 32'h10c); cyc("R3");
        check("R3 zero after dec", res_next_addr, 32'h3000);
        req(3'd0, 1, 2'd0, 0, 0, 32'h5000, 32'h110); cyc("R3");
        check("R3 wrap taken", {31'b0, res_taken}, 1);
        idle_in(); cyc("R3");
        check("R3 wrap value", mv_rdata, 32'hFFFF_FFFF);

        mv(0, 32'd5); cyc("R7");
        req(3'd1, 0, 2'd0, 32'h10, 32'h10, 32'h600, 32'h200); cyc("R2");
        check("R2 cnz_t", {31'b0, res_taken}, 1);
        req(3'd2, 0, 2'd0, 32'h10, 32'h10, 32'h600, 32'h204); cyc("R2");
        check("R2 cnz_f", {31'b0, res_taken}, 0);
        req(3'd4, 0, 2'd0, 32'h10, 32'h10, 32'h600, 32'h208); cyc("R2");
        check("R2 cz_t", {31'b0, res_taken}, 0);
        req(3'd6, 0, 2'd0, 32'h10, 32'h20, 32'h600, 32'h20c); cyc("R2");
        check("R2 bt clear", {31'b0, res_taken}, 0);
        req(3'd7, 0, 2'd0, 32'hFFFF_FFFF, 32'h0, 32'h602, 32'h210); cyc("R2");
        check("R2 bf mask0", res_next_addr, 32'h600);

        req(3'd7, 0, 2'd2, 0, 0, 32'h9999, 32'h4444); br_link = 1; cyc("R4");
        check("R4 lr target old", res_next_addr, 32'h1000);
        idle_in(); mv_sel = 1; cyc("R6");
        check("R6 lr loaded", mv_rdata, 32'h4444);
        req(3'd7, 0, 2'd1, 0, 0, 32'h9999, 32'h0); cyc("R4");
        check("R4 ctr target", res_next_addr, 32'h4);

        req(3'd7, 1, 2'd0, 0, 0, 32'h0, 32'h0); mv_wr = 1; mv_sel = 0; mv_wdata = 32'h77; cyc("R8");
        check("R8 dec wins", mv_rdata, 32'd4);
        req(3'd7, 0, 2'd0, 0, 0, 32'h0, 32'h888); br_link = 1;
        mv_wr = 1; mv_sel = 0; mv_wdata = 32'h99; cyc("R8");
        check("R8 other reg write", mv_rdata, 32'h99);
        idle_in(); mv_sel = 1; cyc("R8");
        check("R8 link kept", mv_rdata, 32'h888);

        for (int i = 0; i < 400; i++) begin
            idle_in();
            br_valid = ($urandom % 4) != 0;
            br_test = 3'($urandom); br_dec = 1'($urandom); br_link = 1'($urandom);
            br_tgt_sel = 2'($urandom);
            br_cond = $urandom; br_mask = ($urandom % 3 == 0) ? 0 : (32'h1 << ($urandom % 32));
            br_target = $urandom; br_seq_addr = $urandom;
            mv_wr = ($urandom % 3) == 0; mv_sel = 1'($urandom); mv_wdata = $urandom % 4;
            cyc("R1 R2 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule